// File: doc/BRIEF.md
# Burst Write Address Router

This block takes a 32-byte write burst of eight 32-bit words and its target address, and sends the burst to one of three consumers. The consumers are a polygon FIFO, a video-format converter and a memory. Two 32-byte staging buffers sit on the source side, and one address bit picks which of them supplies the burst. The low five address bits and every bit above bit 24 are dropped before the address is decoded. An effective address below 8 MiB goes to the polygon port. An address from 8 MiB up to, but not including, 16 MiB goes to the converter. Any higher address goes to memory.

Memory can be written in one of two forms, and a mode input picks the form. In wide form the burst goes out as a single 256-bit write. In word form it goes out as eight 32-bit writes in sequence, and the address of each word is 4 above the previous one. Every port uses a valid/ready handshake. The router takes one burst at a time and captures everything it needs at the moment it accepts the burst.

The router assumes that `rst_n` has already been synchronized to `clk` upstream, so that reset is released on a clock edge.

Top module: `burst_router`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `in_ready` is 1 and all four output valids are 0. A reset that arrives in the middle of a burst abandons that burst.
- R2: Routing uses only the effective address, which is `in_addr & 0x1FFFFE0`. Address bits 31..25 and 4..0 have no effect on the port chosen, on the data or on the memory address.
- R3: When `in_addr` bit 5 is 0, the burst data comes from `stage_a`. When bit 5 is 1, it comes from `stage_b`. Word k of a burst occupies bits [32k+31:32k].
- R4: An effective address below 0x800000 produces exactly one beat on the polygon port, and that beat carries the whole 256-bit burst.
- R5: An effective address from 0x800000 to 0xFFFFE0 produces exactly one 256-bit beat on the converter port.
- R6: An effective address of 0x1000000 or above, with `in_word_mode` = 0, produces exactly one 256-bit beat on the wide memory port. That beat's address is the effective address masked to 23 bits (0x7FFFE0).
- R7: The same memory range with `in_word_mode` = 1 produces eight beats on the word memory port. Beat k carries word k at address (masked effective address + 4k).
- R8: While a burst is in flight, `in_ready` is 0 and at most one output valid is high. `in_ready` returns to 1 in the cycle after the last downstream handshake.
- R9: An output valid that is not met by ready stays high in the next cycle, and its data and address do not change.
- R10: The router samples the staging buffers, the mode and the address only on acceptance. If they change after acceptance, the burst in flight is not affected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A burst is offered |
| in_ready | output | 1 | The router is idle and can accept a burst |
| in_addr | input | 32 | Target address of the burst |
| in_word_mode | input | 1 | Memory form: 0 = one wide write, 1 = eight word writes |
| stage_a | input | 256 | Staging buffer used when address bit 5 is 0 |
| stage_b | input | 256 | Staging buffer used when address bit 5 is 1 |
| poly_valid | output | 1 | Polygon FIFO beat valid |
| poly_ready | input | 1 | Polygon FIFO accepts |
| poly_data | output | 256 | Polygon FIFO burst data |
| cvt_valid | output | 1 | Converter beat valid |
| cvt_ready | input | 1 | Converter accepts |
| cvt_data | output | 256 | Converter burst data |
| mwide_valid | output | 1 | Wide memory write valid |
| mwide_ready | input | 1 | Memory accepts the wide write |
| mwide_addr | output | 23 | Wide write byte address |
| mwide_data | output | 256 | Wide write data |
| mword_valid | output | 1 | Word memory write valid |
| mword_ready | input | 1 | Memory accepts the word |
| mword_addr | output | 23 | Word write byte address |
| mword_data | output | 32 | Word write data |

## Verification
Two events can fall in the same cycle: the last downstream handshake of one burst, and a new burst that has been held on `in_valid` since before that handshake. The bench provokes this by holding `in_valid` high, with a second address, for the whole time the first burst is being drained. It then checks three things: the second burst is not taken early, the first burst's data is not disturbed by the staging buffers that were reloaded for the second, and the second burst is accepted in the cycle right after `in_ready` rises. Each table entry is also run with downstream ready alternating, so that stalls land on single beats and on the final word.

// File: rtl/burst_route_pkg.sv
package burst_route_pkg;
  typedef enum logic [1:0] {
    DST_POLY = 2'd0,
    DST_CVT  = 2'd1,
    DST_MEM  = 2'd2
  } dest_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } seq_state_e;
endpackage

// File: rtl/brt_decode.sv
module brt_decode
  import burst_route_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DEC_AW   = 25,
  parameter int OFS_W    = 5,
  parameter int MEM_AW   = 23,
  parameter int CVT_BASE = 32'h0080_0000,
  parameter int MEM_BASE = 32'h0100_0000
) (
  input  logic [ADDR_W-1:0] addr,
  output dest_e             dest,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              buf_sel
);
  localparam logic [DEC_AW-1:0] CVT_LIM = DEC_AW'(CVT_BASE);
  localparam logic [DEC_AW-1:0] MEM_LIM = DEC_AW'(MEM_BASE);

  logic [DEC_AW-1:0] eff;

  always_comb begin
    eff = {addr[DEC_AW-1:OFS_W], {OFS_W{1'b0}}};
    if (eff < CVT_LIM)      dest = DST_POLY;
    else if (eff < MEM_LIM) dest = DST_CVT;
    else                    dest = DST_MEM;
    mem_addr = eff[MEM_AW-1:0];
    buf_sel  = addr[OFS_W];
  end
endmodule

// File: rtl/brt_stage_sel.sv
module brt_stage_sel #(
  parameter int WORDS  = 8,
  parameter int WORD_W = 32
) (
  input  logic                    sel,
  input  logic [WORDS*WORD_W-1:0] buf_a,
  input  logic [WORDS*WORD_W-1:0] buf_b,
  output logic [WORDS*WORD_W-1:0] data
);
  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign data[w*WORD_W +: WORD_W] = sel ? buf_b[w*WORD_W +: WORD_W]
                                          : buf_a[w*WORD_W +: WORD_W];
  end
endmodule

// File: rtl/brt_seq.sv
module brt_seq
  import burst_route_pkg::*;
#(
  parameter int WORDS = 8,
  localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             serial,
  input  logic             beat_done,
  output logic             busy,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        state_d = ST_SEND;
        cnt_d   = '0;
        cnt_en  = 1'b1;
      end
      ST_SEND: if (beat_done) begin
        if (!serial || cnt_q == LAST) begin
          state_d = ST_IDLE;
        end else begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (state_q == ST_SEND);
  assign cnt  = cnt_q;

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_done |=> busy);
endmodule

// File: rtl/burst_router.sv
module burst_router
  import burst_route_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int WORDS    = 8,
  parameter int WORD_W   = 32,
  parameter int DEC_AW   = 25,
  parameter int MEM_AW   = 23,
  parameter int CVT_BASE = 32'h0080_0000,
  parameter int MEM_BASE = 32'h0100_0000,
  localparam int BURST_W = WORDS * WORD_W,
  localparam int OFS_W   = $clog2(BURST_W / 8),
  localparam int CNT_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_word_mode,
  input  logic [BURST_W-1:0] stage_a,
  input  logic [BURST_W-1:0] stage_b,
  output logic              poly_valid,
  input  logic              poly_ready,
  output logic [BURST_W-1:0] poly_data,
  output logic              cvt_valid,
  input  logic              cvt_ready,
  output logic [BURST_W-1:0] cvt_data,
  output logic              mwide_valid,
  input  logic              mwide_ready,
  output logic [MEM_AW-1:0] mwide_addr,
  output logic [BURST_W-1:0] mwide_data,
  output logic              mword_valid,
  input  logic              mword_ready,
  output logic [MEM_AW-1:0] mword_addr,
  output logic [WORD_W-1:0] mword_data
);
  localparam int BYTE_SH = $clog2(WORD_W / 8);

  dest_e              dec_dest, dest_q;
  logic [MEM_AW-1:0]  dec_maddr, base_q;
  logic               dec_sel;
  logic [BURST_W-1:0] sel_data, data_q;
  logic               serial_q;
  logic               busy, start, beat_done;
  logic [CNT_W-1:0]   cnt;

  brt_decode #(
    .ADDR_W(ADDR_W), .DEC_AW(DEC_AW), .OFS_W(OFS_W), .MEM_AW(MEM_AW),
    .CVT_BASE(CVT_BASE), .MEM_BASE(MEM_BASE)
  ) u_dec (
    .addr(in_addr), .dest(dec_dest), .mem_addr(dec_maddr), .buf_sel(dec_sel)
  );

  brt_stage_sel #(.WORDS(WORDS), .WORD_W(WORD_W)) u_sel (
    .sel(dec_sel), .buf_a(stage_a), .buf_b(stage_b), .data(sel_data)
  );

  assign in_ready = !busy;
  assign start    = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dest_q   <= DST_POLY;
      serial_q <= 1'b0;
      base_q   <= '0;
      data_q   <= '0;
    end else if (start) begin
      dest_q   <= dec_dest;
      serial_q <= (dec_dest == DST_MEM) && in_word_mode;
      base_q   <= dec_maddr;
      data_q   <= sel_data;
    end
  end

  brt_seq #(.WORDS(WORDS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .serial(serial_q),
    .beat_done(beat_done), .busy(busy), .cnt(cnt)
  );

  always_comb begin
    poly_valid  = busy && (dest_q == DST_POLY);
    cvt_valid   = busy && (dest_q == DST_CVT);
    mwide_valid = busy && (dest_q == DST_MEM) && !serial_q;
    mword_valid = busy && (dest_q == DST_MEM) && serial_q;
    beat_done   = (poly_valid && poly_ready) || (cvt_valid && cvt_ready) ||
                  (mwide_valid && mwide_ready) || (mword_valid && mword_ready);
    poly_data   = data_q;
    cvt_data    = data_q;
    mwide_data  = data_q;
    mwide_addr  = base_q;
    mword_addr  = base_q + MEM_AW'({cnt, {BYTE_SH{1'b0}}});
    mword_data  = data_q[cnt*WORD_W +: WORD_W];
  end

  a_r8_one_port: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({poly_valid, cvt_valid, mwide_valid, mword_valid}));

  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);

  a_r9_poly_hold: assert property (@(posedge clk) disable iff (!rst_n)
    poly_valid && !poly_ready |=> poly_valid && $stable(poly_data));

  a_r9_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mword_valid && !mword_ready |=>
      mword_valid && $stable(mword_data) && $stable(mword_addr));

  a_r7_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    mword_valid && mword_ready && (cnt != CNT_W'(WORDS - 1)) |=>
      mword_valid && (mword_addr == $past(mword_addr) + MEM_AW'(WORD_W / 8)));
endmodule

// File: tb/burst_router_test.sv
module burst_router_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [31:0] in_addr = '0;
  logic in_word_mode = 1'b0;
  logic [255:0] stage_a = '0, stage_b = '0;
  logic poly_valid, cvt_valid, mwide_valid, mword_valid;
  logic poly_ready = 1'b0, cvt_ready = 1'b0, mwide_ready = 1'b0, mword_ready = 1'b0;
  logic [255:0] poly_data, cvt_data, mwide_data;
  logic [22:0] mwide_addr, mword_addr;
  logic [31:0] mword_data;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_router uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_word_mode(in_word_mode),
    .stage_a(stage_a), .stage_b(stage_b),
    .poly_valid(poly_valid), .poly_ready(poly_ready), .poly_data(poly_data),
    .cvt_valid(cvt_valid), .cvt_ready(cvt_ready), .cvt_data(cvt_data),
    .mwide_valid(mwide_valid), .mwide_ready(mwide_ready),
    .mwide_addr(mwide_addr), .mwide_data(mwide_data),
    .mword_valid(mword_valid), .mword_ready(mword_ready),
    .mword_addr(mword_addr), .mword_data(mword_data)
  );

  // port codes: 0 polygon, 1 converter, 2 wide memory, 3 word memory
  // entry: {addr[31:0], mode, port[1:0], expected memory address[22:0]}
  localparam int NV = 10;
  localparam logic [57:0] TBL [NV] = '{
    {32'h0000_0000, 1'b0, 2'd0, 23'h000000},
    {32'h007F_FFFF, 1'b1, 2'd0, 23'h000000},
    {32'h0080_0000, 1'b0, 2'd1, 23'h000000},
    {32'h00FF_FFC7, 1'b1, 2'd1, 23'h000000},
    {32'h0100_0000, 1'b0, 2'd2, 23'h000000},
    {32'h01AB_CDE0, 1'b0, 2'd2, 23'h2BCDE0},
    {32'h0100_0040, 1'b1, 2'd3, 23'h000040},
    {32'hFE7F_FFFF, 1'b0, 2'd0, 23'h000000},
    {32'h13FF_FFFF, 1'b1, 2'd3, 23'h7FFFE0},
    {32'h1100_0020, 1'b0, 2'd2, 23'h000020}
  };

  function automatic logic [255:0] pattern(input int seed, input logic b);
    logic [255:0] p;
    for (int i = 0; i < 8; i++)
      p[i*32 +: 32] = (b ? 32'hB000_0000 : 32'hA000_0000) | (32'(seed) << 8) | 32'(i);
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_ready(input logic r);
    poly_ready = r; cvt_ready = r; mwide_ready = r; mword_ready = r;
  endtask

  // Offer one burst; leaves in_valid high when hold is set.
  task automatic offer(input logic [31:0] a, input logic m, input int seed, input bit hold);
    @(negedge clk);
    set_ready(1'b0);
    stage_a = pattern(seed, 1'b0);
    stage_b = pattern(seed, 1'b1);
    in_addr = a; in_word_mode = m; in_valid = 1'b1;
    check(in_ready == 1'b1, "R8 idle ready before offer", 256'(in_ready), 256'd1);
    @(negedge clk);
    if (!hold) in_valid = 1'b0;
  endtask

  // Drain one burst and judge every beat.
  task automatic drain(input int port, input logic [22:0] eaddr, input logic [255:0] edata,
                       input bit stall, input string tag);
    int beats = 0;
    int cyc = 0;
    int expn = (port == 3) ? 8 : 1;
    bit held = 0;
    logic [3:0] v;
    logic r;
    logic [255:0] pd;
    logic [22:0] pa;
    pd = '0; pa = '0;
    while (beats < expn && cyc < 40) begin
      if (cyc > 0) @(negedge clk);
      cyc++;
      v = {mword_valid, mwide_valid, cvt_valid, poly_valid};
      r = stall ? cyc[0] == 1'b0 : 1'b1;
      set_ready(r);
      check(v == 4'(1 << port), {tag, " R4/R5/R6/R7/R8 port select"}, 256'(v), 256'(1 << port));
      check(in_ready == 1'b0, {tag, " R8 busy"}, 256'(in_ready), 256'd0);
      if (held) begin
        case (port)
          0: check(poly_data == pd, {tag, " R9 hold"}, poly_data, pd);
          1: check(cvt_data == pd, {tag, " R9 hold"}, cvt_data, pd);
          2: check(mwide_data == pd && mwide_addr == pa, {tag, " R9 hold"}, mwide_data, pd);
          default: check(mword_data == pd[31:0] && mword_addr == pa, {tag, " R9 hold"},
                         256'(mword_data), pd);
        endcase
      end
      case (port)
        0: begin pd = poly_data; end
        1: begin pd = cvt_data; end
        2: begin pd = mwide_data; pa = mwide_addr; end
        default: begin pd = 256'(mword_data); pa = mword_addr; end
      endcase
      if (v[port] && r) begin
        case (port)
          0: check(poly_data == edata, {tag, " R4/R3 data"}, poly_data, edata);
          1: check(cvt_data == edata, {tag, " R5/R3 data"}, cvt_data, edata);
          2: check(mwide_data == edata && mwide_addr == eaddr, {tag, " R6/R2 data+addr"},
                   {mwide_addr, mwide_data[231:0]}, {eaddr, edata[231:0]});
          default: begin
            check(mword_data == edata[beats*32 +: 32], {tag, " R7/R3 word data"},
                  256'(mword_data), 256'(edata[beats*32 +: 32]));
            check(mword_addr == eaddr + 23'(4 * beats), {tag, " R7/R2 word addr"},
                  256'(mword_addr), 256'(eaddr + 23'(4 * beats)));
          end
        endcase
        beats++;
      end
      held = v[port] && !r;
    end
    check(beats == expn, {tag, " R7 beat count"}, 256'(beats), 256'(expn));
    @(negedge clk);
    set_ready(1'b0);
    check(in_ready == 1'b1, {tag, " R8 ready returns"}, 256'(in_ready), 256'd1);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [57:0] e;
    logic [255:0] exp_a;
    // R1 reset state
    repeat (3) @(negedge clk);
    check(in_ready == 1'b1 && {poly_valid, cvt_valid, mwide_valid, mword_valid} == 4'd0,
          "R1 during reset", 256'({in_ready, poly_valid, cvt_valid, mwide_valid, mword_valid}),
          256'h10);
    @(posedge clk); rst_n <= 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && {poly_valid, cvt_valid, mwide_valid, mword_valid} == 4'd0,
          "R1 after release", 256'({in_ready, poly_valid, cvt_valid, mwide_valid, mword_valid}),
          256'h10);

    // table walk; R10: buffers and mode scrambled right after acceptance
    for (int k = 0; k < NV; k++) begin
      e = TBL[k];
      offer(e[57:26], e[25], k + 1, 1'b0);
      stage_a = ~stage_a; stage_b = ~stage_b; in_word_mode = ~in_word_mode;
      in_addr = ~in_addr;
      drain(int'(e[24:23]), e[22:0], pattern(k + 1, e[31]), k[0], $sformatf("R10 vec%0d", k));
    end

    // overlap: second burst held on in_valid while first drains
    offer(32'h0000_1000, 1'b0, 40, 1'b1);
    exp_a = pattern(40, 1'b0);
    stage_a = pattern(41, 1'b0); stage_b = pattern(41, 1'b1);
    in_addr = 32'h0100_0120; in_word_mode = 1'b1;
    drain(0, 23'h0, exp_a, 1'b1, "R8 overlap first");
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R8 overlap second accepted", 256'(in_ready), 256'd0);
    drain(3, 23'h000120, pattern(41, 1'b1), 1'b0, "R8 overlap second");

    // reset during a word burst abandons it
    offer(32'h0100_0000, 1'b1, 50, 1'b0);
    rst_n = 1'b0;
    #1;
    check(in_ready == 1'b1 && mword_valid == 1'b0, "R1 mid-burst reset",
          256'({in_ready, mword_valid}), 256'h2);
    @(posedge clk); rst_n <= 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1 && {poly_valid, cvt_valid, mwide_valid, mword_valid} == 4'd0,
          "R1 idle after mid-burst reset",
          256'({in_ready, poly_valid, cvt_valid, mwide_valid, mword_valid}), 256'h10);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule